// File: doc/BRIEF.md
# Full-Speed Frame Timer with Done-Queue Interrupt Delay

This block paces the 1 ms frames of a full-speed USB host controller. A 12 MHz bit-time enable drives a countdown. While the controller is operational, the countdown runs from a software-programmed interval value. Each time the countdown passes zero, the frame ends: the 16-bit frame number advances, a start-of-frame pulse is issued, and the countdown reloads. Software can read and write the interval register. It can read the remaining-time register and the frame number. The low five frame-number bits are provided separately so that list logic can choose the periodic slot for the current frame.

The same frame boundaries drive the done-queue interrupt delay. Each retired transfer carries a 3-bit delay code. The pending delay is always the smallest code seen since the last writeback. The code 7 means that no interrupt is wanted. The delay counts down by one per frame. When it has reached zero, and the interrupt logic does not report that the writeback status is still pending, a writeback pulse is raised and the delay returns to 7.

All inputs are plain levels or single-cycle strobes. A retire strobe is accepted in every cycle, so the retire input never applies back-pressure. All pulse outputs last one cycle.

Top module: `usb_frame_timer`

## Requirements
- R1: The interval read value is {toggle bit 31, max-packet field bits 30:16, zeros in bits 15:14, interval bits 13:0}. After reset it reads 0x27782EDF. A write of `intv_wdata` with `intv_we` high loads all three fields on that clock edge.
- R2: The frame number resets to 0. It increases by exactly one per frame boundary and wraps from 0xFFFF to 0x0000. It does not change at any other time.
- R3: On the first cycle that `run` is seen high, the countdown loads the interval value. After that, each bit-time enable lowers it by one. An enable that finds it at 0 is a frame boundary and reloads it from the interval, so one frame lasts interval+1 enables. While operational, bits 13:0 of the remaining read value show the countdown.
- R4: When the block is not operational (operational is `run` delayed by one clock), bits 30:0 of the remaining read value are 0.
- R5: At each boundary, bit 31 of the remaining read value takes the interval toggle bit. `sof_pulse` is high for the single cycle after the boundary edge.
- R6: `fno_pulse` is high for one cycle whenever a boundary changes frame-number bit 15.
- R7: `periodic_slot` always equals frame-number bits 4:0.
- R8: The delay counter resets to 7. A retire strobe with code d sets the counter to d when d is below the counter value after that cycle's frame step.
- R9: At a boundary where the counter is 0 and `wb_busy` is low, `wb_pulse` is raised in the following cycle and the counter returns to 7. If `wb_busy` is high, the counter stays at 0 and no pulse is raised.
- R10: At a boundary, a counter value from 1 to 6 decrements. A value of 7 holds, so a retire with code 7 never leads to a writeback pulse.
- R11: Bit-time enables that arrive while `run` is low have no effect on the frame number or on the start-of-frame pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_en | input | 1 | One-cycle strobe per 12 MHz bit time |
| run | input | 1 | Controller operational |
| intv_we | input | 1 | Write strobe for the interval register |
| intv_wdata | input | 32 | Interval register write data |
| retire_valid | input | 1 | A transfer was retired this cycle |
| retire_dly | input | 3 | Delay code of the retired transfer |
| wb_busy | input | 1 | Writeback status is still pending |
| intv_rd | output | 32 | Interval register read value |
| remain_rd | output | 32 | Remaining-time register read value |
| fnum_rd | output | 16 | Frame number |
| periodic_slot | output | 5 | Periodic list slot for the current frame |
| sof_pulse | output | 1 | Start-of-frame pulse |
| fno_pulse | output | 1 | Frame-number bit 15 changed |
| wb_pulse | output | 1 | Done-queue writeback interrupt event |

## Verification
The bench uses the default parameters: a 14-bit interval, a 16-bit frame number and a 3-bit delay code. It programs intervals between 0 and 20 bit times, so a few thousand cycles contain hundreds of frames and every delay-counter value is visited. With the interval set to 0, every enable is a boundary, so a full 65536-frame wrap of the frame number fits in the run. This also covers both bit-15 transitions. Directed cases cover the delay code 7, a writeback held back by `wb_busy`, and enables that arrive while not operational.

// File: rtl/usb_frame_pkg.sv
package usb_frame_pkg;
  localparam int unsigned DEF_REG_W   = 32;
  localparam int unsigned DEF_FI_W    = 14;
  localparam int unsigned DEF_MPS_W   = 15;
  localparam int unsigned DEF_MPS_LSB = 16;
  localparam int unsigned DEF_FN_W    = 16;
  localparam int unsigned DEF_SLOT_W  = 5;
  localparam int unsigned DEF_DLY_W   = 3;
  localparam int unsigned DEF_RST_FI  = 32'h2EDF;
  localparam int unsigned DEF_RST_MPS = 32'h2778;
endpackage

// File: rtl/fr_interval_reg.sv
module fr_interval_reg #(
  parameter int unsigned REG_W   = usb_frame_pkg::DEF_REG_W,
  parameter int unsigned FI_W    = usb_frame_pkg::DEF_FI_W,
  parameter int unsigned MPS_W   = usb_frame_pkg::DEF_MPS_W,
  parameter int unsigned MPS_LSB = usb_frame_pkg::DEF_MPS_LSB,
  parameter int unsigned RST_FI  = usb_frame_pkg::DEF_RST_FI,
  parameter int unsigned RST_MPS = usb_frame_pkg::DEF_RST_MPS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [REG_W-1:0] wdata,
  output logic [FI_W-1:0]  fi,
  output logic [MPS_W-1:0] mps,
  output logic             fit
);
  localparam logic [FI_W-1:0]  FI_INIT  = FI_W'(RST_FI);
  localparam logic [MPS_W-1:0] MPS_INIT = MPS_W'(RST_MPS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fi  <= FI_INIT;
      mps <= MPS_INIT;
      fit <= 1'b0;
    end else if (we) begin
      fi  <= wdata[FI_W-1:0];
      mps <= wdata[MPS_LSB +: MPS_W];
      fit <= wdata[REG_W-1];
    end
  end

  AST_INTV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> ($stable(fi) && $stable(mps) && $stable(fit))); // R1
endmodule

// File: rtl/fr_frame_count.sv
module fr_frame_count #(
  parameter int unsigned FI_W = usb_frame_pkg::DEF_FI_W,
  parameter int unsigned FN_W = usb_frame_pkg::DEF_FN_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bit_en,
  input  logic            run,
  input  logic [FI_W-1:0] fi,
  input  logic            fit,
  output logic [FI_W-1:0] rem,
  output logic            run_q,
  output logic            frt,
  output logic [FN_W-1:0] fnum,
  output logic            boundary,
  output logic            sof_pulse,
  output logic            fno_pulse
);
  localparam int unsigned FN_MSB = FN_W - 1;

  logic [FN_W-1:0] fn_next;

  assign boundary = run && run_q && bit_en && (rem == '0);
  assign fn_next  = fnum + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem       <= '0;
      run_q     <= 1'b0;
      frt       <= 1'b0;
      fnum      <= '0;
      sof_pulse <= 1'b0;
      fno_pulse <= 1'b0;
    end else begin
      run_q     <= run;
      sof_pulse <= boundary;
      fno_pulse <= boundary && (fn_next[FN_MSB] != fnum[FN_MSB]);
      if (boundary) begin
        rem  <= fi;
        fnum <= fn_next;
        frt  <= fit;
      end else if (run && !run_q) begin
        rem <= fi;
      end else if (run && bit_en) begin
        rem <= rem - 1'b1;
      end
    end
  end

  AST_FN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary |=> $stable(fnum)); // R2
  AST_IDLE_NO_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!sof_pulse && $stable(fnum))); // R11
  AST_SOF_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    boundary |=> (sof_pulse && frt == $past(fit))); // R5
  AST_FNO_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    fno_pulse |-> (fnum[FN_MSB] != $past(fnum[FN_MSB]))); // R6
endmodule

// File: rtl/fr_done_delay.sv
module fr_done_delay #(
  parameter int unsigned DLY_W = usb_frame_pkg::DEF_DLY_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             boundary,
  input  logic             retire_valid,
  input  logic [DLY_W-1:0] retire_dly,
  input  logic             wb_busy,
  output logic             wb_pulse
);
  localparam logic [DLY_W-1:0] IDLE = '1;

  logic [DLY_W-1:0] cnt, stepped, nxt;
  logic             fire;

  always_comb begin
    fire    = 1'b0;
    stepped = cnt;
    if (boundary) begin
      if (cnt == '0) begin
        if (!wb_busy) begin
          fire    = 1'b1;
          stepped = IDLE;
        end
      end else if (cnt != IDLE) begin
        stepped = cnt - 1'b1;
      end
    end
    nxt = stepped;
    if (retire_valid && (retire_dly < stepped)) nxt = retire_dly;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= IDLE;
      wb_pulse <= 1'b0;
    end else begin
      cnt      <= nxt;
      wb_pulse <= fire;
    end
  end

  AST_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> (cnt <= $past(cnt))); // R8
  AST_WB_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && cnt == '0 && !wb_busy) |=> wb_pulse); // R9
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && cnt == '0 && wb_busy) |=> (!wb_pulse && cnt == '0)); // R9
  AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == IDLE && !(retire_valid && retire_dly != IDLE)) |=> (cnt == IDLE && !wb_pulse)); // R10
endmodule

// File: rtl/usb_frame_timer.sv
module usb_frame_timer #(
  parameter int unsigned REG_W   = usb_frame_pkg::DEF_REG_W,
  parameter int unsigned FI_W    = usb_frame_pkg::DEF_FI_W,
  parameter int unsigned MPS_W   = usb_frame_pkg::DEF_MPS_W,
  parameter int unsigned MPS_LSB = usb_frame_pkg::DEF_MPS_LSB,
  parameter int unsigned FN_W    = usb_frame_pkg::DEF_FN_W,
  parameter int unsigned SLOT_W  = usb_frame_pkg::DEF_SLOT_W,
  parameter int unsigned DLY_W   = usb_frame_pkg::DEF_DLY_W,
  parameter int unsigned RST_FI  = usb_frame_pkg::DEF_RST_FI,
  parameter int unsigned RST_MPS = usb_frame_pkg::DEF_RST_MPS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              run,
  input  logic              intv_we,
  input  logic [REG_W-1:0]  intv_wdata,
  input  logic              retire_valid,
  input  logic [DLY_W-1:0]  retire_dly,
  input  logic              wb_busy,
  output logic [REG_W-1:0]  intv_rd,
  output logic [REG_W-1:0]  remain_rd,
  output logic [FN_W-1:0]   fnum_rd,
  output logic [SLOT_W-1:0] periodic_slot,
  output logic              sof_pulse,
  output logic              fno_pulse,
  output logic              wb_pulse
);
  localparam int unsigned GAP_W = MPS_LSB - FI_W;
  localparam int unsigned REM_PAD_W = REG_W - 1 - FI_W;

  logic [FI_W-1:0]  fi, rem;
  logic [MPS_W-1:0] mps;
  logic             fit, frt, run_q, boundary;

  fr_interval_reg #(
    .REG_W(REG_W), .FI_W(FI_W), .MPS_W(MPS_W), .MPS_LSB(MPS_LSB),
    .RST_FI(RST_FI), .RST_MPS(RST_MPS)
  ) u_intv (
    .clk(clk), .rst_n(rst_n), .we(intv_we), .wdata(intv_wdata),
    .fi(fi), .mps(mps), .fit(fit)
  );

  fr_frame_count #(.FI_W(FI_W), .FN_W(FN_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .run(run),
    .fi(fi), .fit(fit), .rem(rem), .run_q(run_q), .frt(frt),
    .fnum(fnum_rd), .boundary(boundary),
    .sof_pulse(sof_pulse), .fno_pulse(fno_pulse)
  );

  fr_done_delay #(.DLY_W(DLY_W)) u_delay (
    .clk(clk), .rst_n(rst_n), .boundary(boundary),
    .retire_valid(retire_valid), .retire_dly(retire_dly),
    .wb_busy(wb_busy), .wb_pulse(wb_pulse)
  );

  generate
    if (GAP_W > 0) begin : g_gap
      assign intv_rd = {fit, mps, {GAP_W{1'b0}}, fi};
    end else begin : g_nogap
      assign intv_rd = {fit, mps, fi};
    end
  endgenerate

  assign remain_rd     = {frt, {REM_PAD_W{1'b0}}, (run_q ? rem : {FI_W{1'b0}})};
  assign periodic_slot = fnum_rd[SLOT_W-1:0];

  AST_SLOT_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    sof_pulse |-> (periodic_slot == SLOT_W'($past(fnum_rd) + 1'b1))); // R7
  AST_REM_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> (remain_rd[REG_W-2:0] == '0)); // R4
endmodule

// File: tb/usb_frame_timer_tb_top.sv
`timescale 1ns/1ps
module usb_frame_timer_tb_top;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n, bit_en, run, intv_we, retire_valid, wb_busy;
  logic [31:0] intv_wdata, intv_rd, remain_rd;
  logic [2:0]  retire_dly;
  logic [15:0] fnum_rd;
  logic [4:0]  periodic_slot;
  logic        sof_pulse, fno_pulse, wb_pulse;

  usb_frame_timer dut_i (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .run(run),
    .intv_we(intv_we), .intv_wdata(intv_wdata),
    .retire_valid(retire_valid), .retire_dly(retire_dly), .wb_busy(wb_busy),
    .intv_rd(intv_rd), .remain_rd(remain_rd), .fnum_rd(fnum_rd),
    .periodic_slot(periodic_slot), .sof_pulse(sof_pulse),
    .fno_pulse(fno_pulse), .wb_pulse(wb_pulse)
  );

  int unsigned n_chk = 0, n_bad = 0;
  bit          finished = 1'b0;

  logic [13:0] m_fi, m_rem;
  logic [14:0] m_mps;
  logic        m_fit, m_frt, m_runq, m_sof, m_fno, m_wb;
  logic [15:0] m_fn;
  logic [2:0]  m_cnt;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_intv(input logic [13:0] fi, input logic [14:0] mps, input logic fit);
    return {fit, mps, 2'b00, fi};
  endfunction

  task automatic model_step(input bit r, input bit be, input bit we, input logic [31:0] wd,
                            input bit rv, input logic [2:0] rd, input bit wbb);
    bit bnd, fire;
    logic [2:0] n;
    bnd  = r && m_runq && be && (m_rem == 14'd0);
    fire = 1'b0;
    m_sof = bnd;
    m_fno = 1'b0;
    if (bnd) begin
      m_fno = ((m_fn + 16'd1) >> 15) != (m_fn >> 15);
      m_fn  = m_fn + 16'd1;
      m_frt = m_fit;
      m_rem = m_fi;
    end else if (r && !m_runq) m_rem = m_fi;
    else if (r && be) m_rem = m_rem - 14'd1;
    n = m_cnt;
    if (bnd) begin
      if (m_cnt == 3'd0) begin
        if (!wbb) begin fire = 1'b1; n = 3'd7; end
      end else if (m_cnt != 3'd7) n = m_cnt - 3'd1;
    end
    if (rv && rd < n) n = rd;
    m_cnt = n;
    m_wb  = fire;
    if (we) begin m_fi = wd[13:0]; m_mps = wd[30:16]; m_fit = wd[31]; end
    m_runq = r;
  endtask

  task automatic compare_all();
    chk("R1 interval read", intv_rd, mk_intv(m_fi, m_mps, m_fit));
    chk("R2 R11 frame number", {16'd0, fnum_rd}, {16'd0, m_fn});
    chk("R7 periodic slot", {27'd0, periodic_slot}, {27'd0, m_fn[4:0]});
    if (m_runq) chk("R3 remaining count", {18'd0, remain_rd[13:0]}, {18'd0, m_rem});
    else        chk("R4 remaining idle", {1'b0, remain_rd[30:0]}, 32'd0);
    chk("R5 remaining toggle", {31'd0, remain_rd[31]}, {31'd0, m_frt});
    chk("R5 sof pulse", {31'd0, sof_pulse}, {31'd0, m_sof});
    chk("R6 fno pulse", {31'd0, fno_pulse}, {31'd0, m_fno});
    chk("R8 R9 R10 wb pulse", {31'd0, wb_pulse}, {31'd0, m_wb});
  endtask

  task automatic cyc(input bit r, input bit be, input bit we, input logic [31:0] wd,
                     input bit rv, input logic [2:0] rd, input bit wbb);
    run = r; bit_en = be; intv_we = we; intv_wdata = wd;
    retire_valid = rv; retire_dly = rd; wb_busy = wbb;
    @(posedge clk);
    model_step(r, be, we, wd, rv, rd, wbb);
    @(negedge clk);
    compare_all();
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not complete actual=hung expected=done");
    finish_run();
  end

  initial begin
    int unsigned seed;
    int sofs, wbs, fnos;
    logic [15:0] fn_hold;
    seed = $urandom(32'h5EED_0042);
    rst_n = 1'b0; bit_en = 0; run = 0; intv_we = 0; intv_wdata = '0;
    retire_valid = 0; retire_dly = '0; wb_busy = 0;
    m_fi = 14'h2EDF; m_mps = 15'h2778; m_fit = 0; m_frt = 0; m_rem = 0;
    m_runq = 0; m_sof = 0; m_fno = 0; m_wb = 0; m_fn = 0; m_cnt = 3'd7;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    chk("R1 reset interval 0x27782EDF", intv_rd, 32'h2778_2EDF);
    chk("R2 reset frame number", {16'd0, fnum_rd}, 32'd0);
    chk("R4 reset remaining", remain_rd, 32'd0);
    compare_all();

    // R1: field write, then R3 countdown cadence with interval 5
    cyc(0, 0, 1, {1'b1, 15'h1234, 2'b11, 14'd5}, 0, 0, 0);
    chk("R1 bits 15:14 read zero", {30'd0, intv_rd[15:14]}, 32'd0);
    sofs = 0;
    for (int i = 0; i < 24; i++) begin
      cyc(1, 1, 0, '0, 0, 0, 0);
      if (sof_pulse) sofs++;
    end
    // first cycle loads, 23 enables -> boundaries at enables 6,12,18
    chk("R3 frame spans interval+1 enables", sofs, 3);

    // R11: enables while not operational
    cyc(0, 1, 0, '0, 0, 0, 0);
    fn_hold = fnum_rd;
    sofs = 0;
    for (int i = 0; i < 12; i++) begin
      cyc(0, 1, 0, '0, 0, 0, 0);
      if (sof_pulse) sofs++;
    end
    chk("R11 frame number unchanged while idle", {16'd0, fnum_rd}, {16'd0, fn_hold});
    chk("R11 no sof while idle", sofs, 0);

    // R8: delay 2 fires on third boundary
    cyc(1, 1, 1, {1'b0, 15'h0100, 2'b00, 14'd2}, 0, 0, 0);
    cyc(1, 1, 0, '0, 1, 3'd2, 0);
    sofs = 0; wbs = 0;
    for (int i = 0; i < 40 && wbs == 0; i++) begin
      cyc(1, 1, 0, '0, 0, 0, 0);
      if (sof_pulse) sofs++;
      if (wb_pulse) wbs++;
    end
    chk("R8 delay code 2 fires on third boundary", sofs, 3);

    // R10: delay code 7 requests nothing
    cyc(1, 1, 0, '0, 1, 3'd7, 0);
    wbs = 0;
    for (int i = 0; i < 40; i++) begin
      cyc(1, 1, 0, '0, 0, 0, 0);
      if (wb_pulse) wbs++;
    end
    chk("R10 code 7 never raises writeback", wbs, 0);

    // R9: busy holds the counter at zero
    cyc(1, 1, 0, '0, 1, 3'd0, 1);
    wbs = 0;
    for (int i = 0; i < 15; i++) begin
      cyc(1, 1, 0, '0, 0, 0, 1);
      if (wb_pulse) wbs++;
    end
    chk("R9 no writeback while busy", wbs, 0);
    wbs = 0;
    for (int i = 0; i < 4; i++) begin
      cyc(1, 1, 0, '0, 0, 0, 0);
      if (wb_pulse) wbs++;
    end
    chk("R9 writeback once busy clears", wbs, 1);

    // constrained random mix
    for (int i = 0; i < 4000; i++) begin
      bit r, be, we, rv, wbb;
      logic [31:0] wd;
      r   = ($urandom % 100) < 90 ? 1'b1 : 1'b0;
      be  = ($urandom % 100) < 70;
      we  = ($urandom % 100) < 3;
      wd  = {$urandom % 2 == 0, 15'($urandom), 2'($urandom), 14'($urandom % 21)};
      rv  = ($urandom % 100) < 25;
      wbb = ($urandom % 100) < 20;
      cyc(r, be, we, wd, rv, 3'($urandom), wbb);
    end

    // R6 / R2: full wrap with interval 0
    cyc(1, 1, 1, 32'd0, 0, 0, 0);
    for (int i = 0; i < 70000 && !(m_fn == 16'd0 && m_rem == 14'd0); i++)
      cyc(1, 1, 0, '0, 0, 0, 0);
    fnos = 0;
    for (int i = 0; i < 65536; i++) begin
      cyc(1, 1, 0, '0, 0, 0, 0);
      if (fno_pulse) fnos++;
    end
    chk("R6 bit 15 changes twice per wrap", fnos, 2);
    chk("R2 frame number wraps to zero", {16'd0, fnum_rd}, 32'd0);

    finish_run();
  end
endmodule